// File: doc/BRIEF.md
# Condition Code Register and Branch Evaluator

This block keeps the four processor status flags: negative, zero, carry and overflow. It decides whether a conditional branch is taken. Each cycle the execute stage presents an ALU result, the ALU's carry-out and overflow, and a four-bit write mask. The mask says which flags that instruction changes. A compare writes all four flags and no result. A shift writes only the carry. A plain move can leave the flags alone.

A branch presents a four-bit condition code, its program counter and a signed word offset. The block tests the condition against the flags and raises the taken output. When the instruction in the same cycle also writes flags, the condition sees the freshly computed values, so no stall is needed. The branch target is always computed as the address of the next instruction plus the sign-extended offset scaled to bytes.

Top module: `cc_branch_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `flags_o` reads 0.
- R2: When a flag's mask bit is 1, that flag is loaded at the clock edge and visible on `flags_o` from the next cycle. N takes the result MSB, Z is 1 when the result is all zeros, C takes `alu_carry_i`, and V takes `alu_ovf_i`. Bit order in `flags_o` and `flag_we_i` is {N,Z,C,V}, with N in bit 3 and V in bit 0.
- R3: With `flag_we_i` = 0, `flags_o` keeps its value whatever the ALU inputs are.
- R4: Each mask bit acts on its own flag only. For example, a mask of 4'b0010 changes C and leaves N, Z and V as they were.
- R5: Condition codes 0 to 3 are, in order: always taken, never taken, equal (Z), and not equal (~Z).
- R6: Condition codes 4 to 7 are the signed tests, with less-than meaning N xor V. In order they are: greater (~Z and ~lt), less-or-equal (Z or lt), greater-or-equal (~lt), and less (lt).
- R7: Condition codes 8 to 15 are, in order: unsigned higher (~C and ~Z), unsigned lower-or-same (C or Z), carry clear, carry set, positive (~N), negative (N), overflow clear, and overflow set.
- R8: `br_taken_o` is 0 whenever `br_valid_i` is 0, for every condition code.
- R9: In a cycle with a non-zero mask, the condition is evaluated on the flags being written. Flags whose mask bit is 1 take their new values. Flags whose mask bit is 0 take their registered values.
- R10: `br_target_o` = `br_pc_i` + 4 + 4 × (`br_offset_i` sign-extended), modulo 2^AW, and it is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_result_i | input | DW | ALU result of the current instruction |
| alu_carry_i | input | 1 | ALU carry-out |
| alu_ovf_i | input | 1 | ALU signed overflow |
| flag_we_i | input | 4 | Per-flag write mask {N,Z,C,V} |
| br_valid_i | input | 1 | A conditional branch is being evaluated |
| br_cond_i | input | 4 | Condition code 0..15 |
| br_pc_i | input | AW | Byte address of the branch |
| br_offset_i | input | OW | Signed offset in instructions |
| br_taken_o | output | 1 | Branch taken |
| br_target_o | output | AW | Branch target byte address |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
All sixteen condition codes are tried against all sixteen combinations of the four flags. This distinguishes every pair of signed and unsigned relations, such as greater against higher, and any mix-up of the N xor V term. Single-flag masks separate a correct per-flag enable from one that writes all four flags. Back-to-back cases, where the instruction writes flags in the same cycle as a branch, separate the forwarded path from the registered one, including a partial mask where Z must come from the register. Offsets of +5, −1 and both ends of the 16-bit range check the sign extension and the scaling of the target.

// File: rtl/ccb_pkg.sv
package ccb_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } ccb_flags_t;

  typedef enum logic [3:0] {
    CC_AL = 4'd0,  CC_NV = 4'd1,  CC_EQ = 4'd2,  CC_NE = 4'd3,
    CC_GT = 4'd4,  CC_LE = 4'd5,  CC_GE = 4'd6,  CC_LT = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_CC = 4'd10, CC_CS = 4'd11,
    CC_PL = 4'd12, CC_MI = 4'd13, CC_VC = 4'd14, CC_VS = 4'd15
  } ccb_cond_e;

  localparam int NUM_COND = 16;

  // signed less-than from the stored flags
  function automatic logic signed_less(ccb_flags_t f);
    return f.n ^ f.v;
  endfunction

  // masked merge of new flags over old ones
  function automatic ccb_flags_t merge_flags(ccb_flags_t old_f, ccb_flags_t new_f,
                                             logic [3:0] we);
    logic [3:0] o, n;
    o = old_f;
    n = new_f;
    return ccb_flags_t'((n & we) | (o & ~we));
  endfunction

  function automatic logic cond_hit(ccb_cond_e code, ccb_flags_t f);
    logic lt;
    logic r;
    lt = signed_less(f);
    case (code)
      CC_AL: r = 1'b1;
      CC_NV: r = 1'b0;
      CC_EQ: r = f.z;
      CC_NE: r = ~f.z;
      CC_GT: r = ~(f.z | lt);
      CC_LE: r = f.z | lt;
      CC_GE: r = ~lt;
      CC_LT: r = lt;
      CC_HI: r = ~(f.c | f.z);
      CC_LS: r = f.c | f.z;
      CC_CC: r = ~f.c;
      CC_CS: r = f.c;
      CC_PL: r = ~f.n;
      CC_MI: r = f.n;
      CC_VC: r = ~f.v;
      default: r = f.v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ccb_flag_gen.sv
module ccb_flag_gen
  import ccb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] result_i,
  input  logic          carry_i,
  input  logic          ovf_i,
  output ccb_flags_t    flags_o
);

  logic res_neg;
  logic res_zero;

  assign res_neg  = result_i[DW-1];
  assign res_zero = ~|result_i;

  always_comb begin
    flags_o.n = res_neg;
    flags_o.z = res_zero;
    flags_o.c = carry_i;
    flags_o.v = ovf_i;
  end

endmodule

// File: rtl/ccb_flag_reg.sv
module ccb_flag_reg
  import ccb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ccb_flags_t new_i,
  input  logic [3:0] we_i,
  output ccb_flags_t cur_o,
  output ccb_flags_t fwd_o
);

  ccb_flags_t flag_q;

  assign fwd_o = merge_flags(flag_q, new_i, we_i);
  assign cur_o = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= fwd_o;
  end

endmodule

// File: rtl/ccb_cond_eval.sv
module ccb_cond_eval
  import ccb_pkg::*;
(
  input  ccb_flags_t flags_i,
  input  logic       valid_i,
  input  logic [3:0] cond_i,
  output logic       taken_o
);

  logic [NUM_COND-1:0] cond_vec;

  for (genvar k = 0; k < NUM_COND; k++) begin : g_cond
    assign cond_vec[k] = cond_hit(ccb_cond_e'(4'(k)), flags_i);
  end

  assign taken_o = valid_i & cond_vec[cond_i];

endmodule

// File: rtl/ccb_target_calc.sv
module ccb_target_calc #(
  parameter int AW         = 32,
  parameter int OW         = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] target_o
);

  localparam int SH = $clog2(INSN_BYTES);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  function automatic logic [AW-1:0] scaled_offset(logic [OW-1:0] off);
    logic [AW-1:0] ext;
    ext = AW'($signed(off));
    return ext << SH;
  endfunction

  assign target_o = pc_i + STEP + scaled_offset(off_i);

endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import ccb_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int OW         = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] alu_result_i,
  input  logic          alu_carry_i,
  input  logic          alu_ovf_i,
  input  logic [3:0]    flag_we_i,
  input  logic          br_valid_i,
  input  logic [3:0]    br_cond_i,
  input  logic [AW-1:0] br_pc_i,
  input  logic [OW-1:0] br_offset_i,
  output logic          br_taken_o,
  output logic [AW-1:0] br_target_o,
  output logic [3:0]    flags_o
);

  ccb_flags_t alu_flags;
  ccb_flags_t cur_flags;
  ccb_flags_t fwd_flags;

  ccb_flag_gen #(.DW(DW)) u_gen (
    .result_i (alu_result_i),
    .carry_i  (alu_carry_i),
    .ovf_i    (alu_ovf_i),
    .flags_o  (alu_flags)
  );

  ccb_flag_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .new_i (alu_flags),
    .we_i  (flag_we_i),
    .cur_o (cur_flags),
    .fwd_o (fwd_flags)
  );

  ccb_cond_eval u_eval (
    .flags_i (fwd_flags),
    .valid_i (br_valid_i),
    .cond_i  (br_cond_i),
    .taken_o (br_taken_o)
  );

  ccb_target_calc #(.AW(AW), .OW(OW), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .pc_i     (br_pc_i),
    .off_i    (br_offset_i),
    .target_o (br_target_o)
  );

  assign flags_o = cur_flags;

endmodule

// File: rtl/ccb_checker.sv
module ccb_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] alu_result_i,
  input logic [3:0]    flag_we_i,
  input logic          br_valid_i,
  input logic [3:0]    br_cond_i,
  input logic          br_taken_o,
  input logic [3:0]    flags_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> flags_o == 4'b0);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i == 4'b0 |=> $stable(flags_o));

  // R2
  n_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i[3] |=> flags_o[3] == $past(alu_result_i[DW-1]));

  // R2
  z_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i[2] |=> flags_o[2] == ($past(alu_result_i) == '0));

  // R5
  never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_cond_i == 4'd1 |-> !br_taken_o);

  // R8
  idle_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid_i |-> !br_taken_o);

  // R9
  eq_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid_i && br_cond_i == 4'd2 && flag_we_i[2]) |-> br_taken_o == (alu_result_i == '0));

endmodule

bind cc_branch_unit ccb_checker #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alu_result_i (alu_result_i),
  .flag_we_i    (flag_we_i),
  .br_valid_i   (br_valid_i),
  .br_cond_i    (br_cond_i),
  .br_taken_o   (br_taken_o),
  .flags_o      (flags_o)
);

// File: tb/cc_branch_unit_tb.sv
module cc_branch_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] alu_result_i = '0;
  logic        alu_carry_i = 1'b0;
  logic        alu_ovf_i = 1'b0;
  logic [3:0]  flag_we_i = '0;
  logic        br_valid_i = 1'b0;
  logic [3:0]  br_cond_i = '0;
  logic [31:0] br_pc_i = '0;
  logic [15:0] br_offset_i = '0;
  logic        br_taken_o;
  logic [31:0] br_target_o;
  logic [3:0]  flags_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cc_branch_unit u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_taken(int c, bit n, bit z, bit cy, bit v);
    bit lt;
    lt = (n != v);
    case (c)
      0: return 1;          1: return 0;
      2: return z;          3: return !z;
      4: return !z && !lt;  5: return z || lt;
      6: return !lt;        7: return lt;
      8: return !cy && !z;  9: return cy || z;
      10: return !cy;       11: return cy;
      12: return !n;        13: return n;
      14: return !v;        default: return v;
    endcase
  endfunction

  task automatic set_flags(input bit n, input bit z, input bit cy, input bit v);
    @(negedge clk);
    alu_result_i = z ? 32'h0 : 32'h1;
    flag_we_i = 4'b0100;
    @(negedge clk);
    alu_result_i = n ? 32'h8000_0000 : 32'h2;
    alu_carry_i = cy;
    alu_ovf_i = v;
    flag_we_i = 4'b1011;
    @(negedge clk);
    flag_we_i = 4'b0;
    chk("R4 staged flag load", flags_o, {n, z, cy, v});
  endtask

  task automatic t_reset();
    chk("R1 flags during reset", flags_o, 4'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", flags_o, 4'b0);
  endtask

  task automatic t_full_write();
    @(negedge clk);
    alu_result_i = 32'h8000_0000; alu_carry_i = 1; alu_ovf_i = 0; flag_we_i = 4'b1111;
    @(negedge clk);
    chk("R2 negative with carry", flags_o, 4'b1010);
    alu_result_i = 32'h0; alu_carry_i = 0; alu_ovf_i = 1;
    @(negedge clk);
    chk("R2 zero with overflow", flags_o, 4'b0101);
    flag_we_i = 4'b0;
  endtask

  task automatic t_hold();
    @(negedge clk);
    alu_result_i = 32'hFFFF_FFFF; alu_carry_i = 1; alu_ovf_i = 0; flag_we_i = 4'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 hold with mask zero", flags_o, 4'b0101);
  endtask

  task automatic t_carry_only();
    @(negedge clk);
    alu_result_i = 32'h8000_0000; alu_carry_i = 1; alu_ovf_i = 0; flag_we_i = 4'b0010;
    @(negedge clk);
    flag_we_i = 4'b0;
    chk("R4 carry-only update", flags_o, 4'b0111);
  endtask

  task automatic t_all_conds();
    for (int f = 0; f < 16; f++) begin
      set_flags(f[3], f[2], f[1], f[0]);
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        br_valid_i = 1; br_cond_i = 4'(c);
        #1;
        if (c < 4)      chk($sformatf("R5 cond %0d flags %0h", c, f), br_taken_o, exp_taken(c, f[3], f[2], f[1], f[0]));
        else if (c < 8) chk($sformatf("R6 cond %0d flags %0h", c, f), br_taken_o, exp_taken(c, f[3], f[2], f[1], f[0]));
        else            chk($sformatf("R7 cond %0d flags %0h", c, f), br_taken_o, exp_taken(c, f[3], f[2], f[1], f[0]));
      end
    end
    @(negedge clk);
    br_valid_i = 0;
  endtask

  task automatic t_invalid();
    set_flags(1, 1, 1, 1);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      br_valid_i = 0; br_cond_i = 4'(c);
      #1;
      chk($sformatf("R8 invalid cond %0d", c), br_taken_o, 1'b0);
    end
  endtask

  task automatic t_forward();
    set_flags(0, 0, 0, 0);
    @(negedge clk);
    alu_result_i = 32'h0; alu_carry_i = 1; alu_ovf_i = 0; flag_we_i = 4'b1111;
    br_valid_i = 1; br_cond_i = 4'd2;
    #1;
    chk("R9 forwarded Z for EQ", br_taken_o, 1'b1);
    br_cond_i = 4'd11;
    #1;
    chk("R9 forwarded C for CS", br_taken_o, 1'b1);
    @(negedge clk);
    chk("R2 flags after forward cycle", flags_o, 4'b0110);
    alu_result_i = 32'h5; alu_carry_i = 0; flag_we_i = 4'b0010;
    br_cond_i = 4'd2;
    #1;
    chk("R9 partial mask keeps registered Z", br_taken_o, 1'b1);
    br_cond_i = 4'd11;
    #1;
    chk("R9 partial mask forwards new C", br_taken_o, 1'b0);
    @(negedge clk);
    flag_we_i = 4'b0; br_valid_i = 0;
    chk("R4 partial mask result", flags_o, 4'b0100);
  endtask

  task automatic t_target();
    logic [15:0] offs [4] = '{16'h0005, 16'hFFFF, 16'h8000, 16'h7FFF};
    for (int i = 0; i < 4; i++) begin
      longint e;
      @(negedge clk);
      br_pc_i = 32'h0000_1000; br_offset_i = offs[i];
      e = 64'h1000 + 4 + longint'($signed(offs[i])) * 4;
      #1;
      chk($sformatf("R10 target offset %0h", offs[i]), br_target_o, 64'(e[31:0]));
    end
  endtask

  initial begin
    t_reset();
    t_full_write();
    t_hold();
    t_carry_only();
    t_all_conds();
    t_invalid();
    t_forward();
    t_target();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule